// File: doc/BRIEF.md
# Source pixel format unpacker

This block sits at the front of a 2D blit pipeline. It takes one 32-bit source word together with a format code and expands it into pixels in a common 32-bit working layout: alpha in bits 31:24, then red in 23:16, green in 15:8 and blue in 7:0. Narrow colour and alpha fields are widened to 8 bits by copying their top bits into the vacated low bits. Formats without a stored alpha get an opaque alpha. The 4:2:2 luma/chroma formats are delivered as Y/U/V triples in the same lanes: Cr in 23:16, Y in 15:8 and Cb in 7:0, with alpha 0xFF.

Depending on the format, a word yields one or two pixels. Each pixel is offered on a valid/ready output, and the last pixel of a word carries a last flag. While a word is still being emitted, the input side is held off by a low `in_ready`.

A three-state controller sequences the output. The states are ST_IDLE (no word held), ST_LEAD (first or only pixel on the output) and ST_TRAIL (second pixel of a pair on the output). The transitions are:
- IDLE→LEAD when a word is accepted.
- LEAD→TRAIL when a pair format's first pixel is taken.
- LEAD→LEAD or TRAIL→LEAD when the last pixel is taken and a new word is accepted in the same cycle.
- LEAD→IDLE or TRAIL→IDLE when the last pixel is taken and no new word arrives.

Top module: `src_pixel_unpacker`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Format codes are: 0 A1R5G5B5, 1 A4R4G4B4, 2 X1R5G5B5, 3 X4R4G4B4, 4 R5G6B5, 5 A8R8G8B8, 6 X8R8G8B8, 7 A8, 8 YUYV, 9 UYVY.
- R3: Codes 0–4 produce two pixels per word. The first is decoded from bits 15:0 and the second from bits 31:16. `out_last` is 0 on the first pixel and 1 on the second.
- R4: In codes 0 and 2 the halfword fields are alpha bit 15, red 14:10, green 9:5 and blue 4:0. A 5-bit field v widens to {v, v[4:2]}. For code 0, alpha bit 0 gives 0x00 and alpha bit 1 gives 0xFF.
- R5: In codes 1 and 3 the fields are alpha 15:12, red 11:8, green 7:4 and blue 3:0. A 4-bit field v widens to {v, v}.
- R6: In code 4 the fields are red 15:11, green 10:5 and blue 4:0. Green widens to {g, g[5:4]}, and the output alpha is 0xFF.
- R7: For codes 2, 3 and 6 the stored alpha bits are ignored and the output alpha is 0xFF.
- R8: Code 5 passes the word through unchanged. Code 6 outputs {0xFF, word[23:0]}. Both produce one pixel with `out_last` = 1.
- R9: Code 7 outputs {word[7:0], 24'h0} as one pixel with `out_last` = 1. Bits 31:8 are ignored.
- R10: Code 8 reads bytes from bit 0 upward as Y0, Cb, Y1, Cr. It emits {0xFF, Cr, Y0, Cb} and then {0xFF, Cr, Y1, Cb}, with `out_last` on the second.
- R11: Code 9 reads bytes from bit 0 upward as Cb, Y0, Cr, Y1. It emits the same two pixels in the same order as code 8.
- R12: Both pixels of a code 8 or code 9 word carry identical Cr and Cb lanes.
- R13: While `out_valid` is 1 and `out_ready` is 0, `out_pixel` and `out_last` hold steady. `in_ready` stays 0 while a non-last pixel is on the output.
- R14: Codes 10–15 produce one pixel of value 0 with `out_last` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_fmt | input | 4 | Format code of the word |
| in_word | input | 32 | Packed source word |
| out_valid | output | 1 | Pixel present on `out_pixel` |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | 32 | Unpacked pixel, alpha/red/green/blue or FF/Cr/Y/Cb |
| out_last | output | 1 | Pixel is the final one of its word |

## Verification
The assertions watch the handshake on every cycle:
- A held pixel stays stable under backpressure.
- Input is refused while a first-of-pair pixel waits.
- A taken non-last pixel is always followed by the last one.
- Opaque formats always show alpha 0xFF.
- The alpha-only format has zero colour.
- The two pixels of a luma/chroma pair share chroma.

The exact bit positions, the replication of narrow fields, the halfword and byte ordering, and the treatment of reserved codes can only be shown by the bench. It drives a range of words in every format, with and without random backpressure, and compares each pixel against an independently computed expectation.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    localparam int FMT_W  = 4;
    localparam int CH_W   = 8;
    localparam int PIX_W  = 4 * CH_W;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [FMT_W-1:0] {
        FMT_A1RGB555 = 4'd0,
        FMT_A4RGB444 = 4'd1,
        FMT_X1RGB555 = 4'd2,
        FMT_X4RGB444 = 4'd3,
        FMT_RGB565   = 4'd4,
        FMT_ARGB8888 = 4'd5,
        FMT_XRGB8888 = 4'd6,
        FMT_ALPHA8   = 4'd7,
        FMT_YUYV     = 4'd8,
        FMT_UYVY     = 4'd9
    } pix_fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    // Widen an n-bit field held in the low bits of v to CH_W bits by
    // repeating its most significant bits into the low positions.
    function automatic logic [CH_W-1:0] widen(input logic [CH_W-1:0] v, input int n);
        logic [CH_W-1:0] res;
        int k;
        for (int i = 0; i < CH_W; i++) begin
            k = (n - 1) - (((CH_W - 1) - i) % n);
            res[i] = v[k[2:0]];
        end
        return res;
    endfunction

    // Formats whose word holds two pixels.
    function automatic logic fmt_is_pair(input logic [FMT_W-1:0] f);
        return (f <= 4'd4) || (f == 4'd8) || (f == 4'd9);
    endfunction

    // Formats whose output alpha is always opaque.
    function automatic logic fmt_is_opaque(input logic [FMT_W-1:0] f);
        return (f == 4'd2) || (f == 4'd3) || (f == 4'd4) || (f == 4'd6) ||
               (f == 4'd8) || (f == 4'd9);
    endfunction

endpackage

// File: rtl/unpack_decode.sv
module unpack_decode
    import pix_unpack_pkg::*;
(
    input  logic [FMT_W-1:0]  fmt,
    input  logic [WORD_W-1:0] word,
    input  logic              slot,
    output logic [PIX_W-1:0]  pixel
);

    logic [HALF_W-1:0] half;
    logic [CH_W-1:0]   b0, b1, b2, b3;
    argb_t             p555, p444, p565, pyuv;
    logic [CH_W-1:0]   luma, cb, cr;

    assign half = slot ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    assign b0   = word[7:0];
    assign b1   = word[15:8];
    assign b2   = word[23:16];
    assign b3   = word[31:24];

    // 1-5-5-5 layout
    always_comb begin
        p555.a = {CH_W{half[15]}};
        p555.r = widen({3'b000, half[14:10]}, 5);
        p555.g = widen({3'b000, half[9:5]}, 5);
        p555.b = widen({3'b000, half[4:0]}, 5);
    end

    // 4-4-4-4 layout
    always_comb begin
        p444.a = widen({4'h0, half[15:12]}, 4);
        p444.r = widen({4'h0, half[11:8]}, 4);
        p444.g = widen({4'h0, half[7:4]}, 4);
        p444.b = widen({4'h0, half[3:0]}, 4);
    end

    // 5-6-5 layout
    always_comb begin
        p565.a = 8'hFF;
        p565.r = widen({3'b000, half[15:11]}, 5);
        p565.g = widen({2'b00, half[10:5]}, 6);
        p565.b = widen({3'b000, half[4:0]}, 5);
    end

    // luma/chroma byte selection for the two 4:2:2 orders
    always_comb begin
        if (fmt == FMT_UYVY) begin
            cb   = b0;
            cr   = b2;
            luma = slot ? b3 : b1;
        end else begin
            cb   = b1;
            cr   = b3;
            luma = slot ? b2 : b0;
        end
        pyuv.a = 8'hFF;
        pyuv.r = cr;
        pyuv.g = luma;
        pyuv.b = cb;
    end

    always_comb begin
        unique case (fmt)
            FMT_A1RGB555: pixel = p555;
            FMT_X1RGB555: pixel = {8'hFF, p555.r, p555.g, p555.b};
            FMT_A4RGB444: pixel = p444;
            FMT_X4RGB444: pixel = {8'hFF, p444.r, p444.g, p444.b};
            FMT_RGB565:   pixel = p565;
            FMT_ARGB8888: pixel = word;
            FMT_XRGB8888: pixel = {8'hFF, word[23:0]};
            FMT_ALPHA8:   pixel = {b0, 24'h000000};
            FMT_YUYV,
            FMT_UYVY:     pixel = pyuv;
            default:      pixel = '0;
        endcase
    end

endmodule

// File: rtl/unpack_ctrl.sv
module unpack_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic held_pair,
    input  logic out_ready,
    output logic in_ready,
    output logic load,
    output logic slot,
    output logic out_valid,
    output logic out_last
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } ctrl_state_e;

    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        load      = 1'b0;
        slot      = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
                state_d  = in_valid ? ST_LEAD : ST_IDLE;
            end
            ST_LEAD: begin
                out_valid = 1'b1;
                out_last  = !held_pair;
                if (out_ready) begin
                    if (held_pair) begin
                        state_d = ST_TRAIL;
                    end else begin
                        in_ready = 1'b1;
                        load     = in_valid;
                        state_d  = in_valid ? ST_LEAD : ST_IDLE;
                    end
                end
            end
            ST_TRAIL: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
                slot      = 1'b1;
                if (out_ready) begin
                    in_ready = 1'b1;
                    load     = in_valid;
                    state_d  = in_valid ? ST_LEAD : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R13: no new word while the first pixel of a pair waits
    a_r13_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    // R3: a taken non-last pixel is followed by the closing pixel
    a_r3_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && out_last));

endmodule

// File: rtl/src_pixel_unpacker.sv
module src_pixel_unpacker
    import pix_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FMT_W-1:0]  in_fmt,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_pixel,
    output logic              out_last
);

    logic [FMT_W-1:0]  fmt_q;
    logic [WORD_W-1:0] word_q;
    logic              load;
    logic              slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= '0;
            word_q <= '0;
        end else if (load) begin
            fmt_q  <= in_fmt;
            word_q <= in_word;
        end
    end

    unpack_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .held_pair (fmt_is_pair(fmt_q)),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .load      (load),
        .slot      (slot),
        .out_valid (out_valid),
        .out_last  (out_last)
    );

    unpack_decode dec_i (
        .fmt   (fmt_q),
        .word  (word_q),
        .slot  (slot),
        .pixel (out_pixel)
    );

    // R13: output held under backpressure
    a_r13_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_last)));

    // R7: opaque formats always present alpha 0xFF
    a_r7_alpha_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_is_opaque(fmt_q)) |-> (out_pixel[31:24] == 8'hFF));

    // R9: alpha-only pixels carry no colour
    a_r9_colour_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_q == FMT_ALPHA8) |-> (out_pixel[23:0] == 24'h0));

    // R12: both pixels of a luma/chroma pair share chroma
    a_r12_chroma_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last && (fmt_q == FMT_YUYV || fmt_q == FMT_UYVY))
        |=> (out_pixel[23:16] == $past(out_pixel[23:16]) && out_pixel[7:0] == $past(out_pixel[7:0])));

endmodule

// File: tb/src_pixel_unpacker_tb_top.sv
module src_pixel_unpacker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_fmt = '0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_pixel;
    logic        out_last;

    int checks = 0;
    int failures = 0;
    logic bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] exp_pix_q[$];
    logic        exp_last_q[$];
    string       exp_tag_q[$];

    always #10 clk = ~clk;

    src_pixel_unpacker dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_word(in_word), .out_valid(out_valid),
        .out_ready(out_ready), .out_pixel(out_pixel), .out_last(out_last)
    );

    function automatic logic [31:0] model_half(input logic [3:0] f, input logic [15:0] h);
        logic [23:0] c555, c444;
        c555 = {h[14:10], h[14:12], h[9:5], h[9:7], h[4:0], h[4:2]};
        c444 = {h[11:8], h[11:8], h[7:4], h[7:4], h[3:0], h[3:0]};
        case (f)
            4'd0: return {(h[15] ? 8'hFF : 8'h00), c555};
            4'd1: return {h[15:12], h[15:12], c444};
            4'd2: return {8'hFF, c555};
            4'd3: return {8'hFF, c444};
            default: return {8'hFF, h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
        endcase
    endfunction

    task automatic push(input logic [31:0] p, input logic l, input string t);
        exp_pix_q.push_back(p);
        exp_last_q.push_back(l);
        exp_tag_q.push_back(t);
    endtask

    task automatic expect_word(input logic [3:0] f, input logic [31:0] w);
        if (f <= 4'd4) begin
            push(model_half(f, w[15:0]), 1'b0, "R3");
            push(model_half(f, w[31:16]), 1'b1, "R4/R5/R6 second half");
        end else if (f == 4'd5) push(w, 1'b1, "R8");
        else if (f == 4'd6) push({8'hFF, w[23:0]}, 1'b1, "R8/R7");
        else if (f == 4'd7) push({w[7:0], 24'h0}, 1'b1, "R9");
        else if (f == 4'd8) begin
            push({8'hFF, w[31:24], w[7:0], w[15:8]}, 1'b0, "R10");
            push({8'hFF, w[31:24], w[23:16], w[15:8]}, 1'b1, "R10/R12");
        end else if (f == 4'd9) begin
            push({8'hFF, w[23:16], w[15:8], w[7:0]}, 1'b0, "R11");
            push({8'hFF, w[23:16], w[31:24], w[7:0]}, 1'b1, "R11/R12");
        end else push(32'h0, 1'b1, "R14");
    endtask

    // driver: called at a falling edge, returns at the falling edge after acceptance (R2)
    task automatic send(input logic [3:0] f, input logic [31:0] w);
        logic ok;
        expect_word(f, w);
        in_valid = 1'b1;
        in_fmt = f;
        in_word = w;
        ok = 1'b0;
        while (!ok) begin
            #8 ok = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic send_all();
        send(4'd0, 32'h8000_7C1F);
        send(4'd0, 32'h03E0_FFFF);
        send(4'd1, 32'h1234_F0A5);
        send(4'd2, 32'hFFFF_0421);
        send(4'd2, 32'h7FFF_8000);
        send(4'd3, 32'h0ABC_F123);
        send(4'd4, 32'hF800_07E0);
        send(4'd4, 32'h001F_8A51);
        send(4'd5, 32'h1122_3344);
        send(4'd6, 32'h00AB_CDEF);
        send(4'd7, 32'hDEAD_BE5A);
        send(4'd8, 32'hC35A_9621);
        send(4'd9, 32'h8040_C010);
        send(4'd12, 32'hFFFF_FFFF);
        send(4'd15, 32'h1234_5678);
    endtask

    // backpressure source
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= bp_en ? lfsr[0] : 1'b1;
    end

    // monitor / scoreboard
    initial begin
        logic        prev_stall = 1'b0;
        logic [31:0] prev_pix = '0;
        logic        prev_last = 1'b0;
        forever begin
            @(negedge clk);
            #8;
            if (rst_n) begin
                if (prev_stall) begin
                    checks++;
                    if (!out_valid || out_pixel !== prev_pix || out_last !== prev_last) begin
                        failures++;
                        $display("FAIL R13 hold: got v=%0b pix=%h last=%0b expected pix=%h last=%0b",
                                 out_valid, out_pixel, out_last, prev_pix, prev_last);
                    end
                end
                if (out_valid && !out_last) begin
                    checks++;
                    if (in_ready) begin
                        failures++;
                        $display("FAIL R13 in_ready: got 1 expected 0 during first of pair");
                    end
                end
                if (out_valid && out_ready) begin
                    checks++;
                    if (exp_pix_q.size() == 0) begin
                        failures++;
                        $display("FAIL R2 unexpected pixel: got %h expected none", out_pixel);
                    end else begin
                        logic [31:0] ep;
                        logic el;
                        string et;
                        ep = exp_pix_q.pop_front();
                        el = exp_last_q.pop_front();
                        et = exp_tag_q.pop_front();
                        if (out_pixel !== ep || out_last !== el) begin
                            failures++;
                            $display("FAIL %s: got pix=%h last=%0b expected pix=%h last=%0b",
                                     et, out_pixel, out_last, ep, el);
                        end
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_pix = out_pixel;
                prev_last = out_last;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got hang expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #8;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            failures++;
            $display("FAIL R1: got out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end
        @(negedge clk);
        send_all();
        repeat (6) @(negedge clk);
        bp_en = 1'b1;
        send_all();
        send_all();
        for (int i = 0; i < 400 && exp_pix_q.size() != 0; i++) @(negedge clk);
        checks++;
        if (exp_pix_q.size() != 0) begin
            failures++;
            $display("FAIL R3: got %0d pixels outstanding expected 0", exp_pix_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule